// File: doc/BRIEF.md
# Cascaded Event Interrupt Controller

The block gathers single-bit hardware events into three pending words of `WORD_W` bits and turns that pending state into a small set of level-type interrupt requests. An event is named by a 7-bit number. A raise sets the addressed pending bit. A hardware clear removes it. The second and third pending words each own a summary bit at the top of the first word. This gives a handler one word to poll before it looks at the others.

Software reaches the block through a plain register bus. It can read the three pending words and a bank of mask registers. Each pending word has its own write rule: the first word is write-one-to-clear except for its two summary bits, the second cannot be written, and the third is write-one-to-clear and pulls its summary bit down when it empties. Each interrupt output has one mask per pending word and asserts when any unmasked pending bit is set.

Top module: `evt_cascade_irq`

## Requirements
- R1: An event number splits into a word select (bits [6:5]) and a bit select (bits [4:0]). A valid raise sets that bit of pending word 0, 1 or 2 at the next clock edge.
- R2: Raising an event in word 1 (numbers 32 to 63) also sets bit 30 of word 0. Raising an event in word 2 (numbers 64 to 95) also sets bit 31 of word 0.
- R3: A hardware clear removes the named bit. If word 1 is then all-zero, bit 30 of word 0 drops. If word 2 is then all-zero, bit 31 of word 0 drops. Otherwise the summary bits are unchanged.
- R4: A bus write to address 0 clears every bit of word 0 that is 1 in the write data, except bits 31 and 30, which are kept.
- R5: A bus write to address 1 leaves word 1 unchanged.
- R6: A bus write to address 2 clears every bit of word 2 that is 1 in the write data. If word 2 is then all-zero, bit 31 of word 0 drops in the same cycle.
- R7: irq_out[0] (level 13), irq_out[1] (level 11) and irq_out[2] (level 9) are each the OR over the three words of pending AND that level's mask. Each output is registered, so it follows a pending change one clock later.
- R8: The mask registers are plain read/write. For level index L (0 = level 13, 1 = level 11, 2 = level 9) and word w, the mask sits at address 3 + 3*L + w.
- R9: Synchronous reset clears all pending words, masks, interrupt outputs and read data.
- R10: When a raise and a hardware clear, or a raise and a bus write-one-to-clear, hit the same bit in the same cycle, the bit ends up set.
- R11: Raise and clear requests with event numbers 96 to 127 have no effect. Requests naming event 30 or 31 also have no effect.
- R12: bus_rdata shows the register at bus_addr one clock after the address is presented. Addresses 12 to 15 read as zero, and writes to them have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ev_raise_valid | input | 1 | Raise request strobe |
| ev_raise_num | input | 7 | Event number to raise |
| ev_clear_valid | input | 1 | Hardware clear strobe |
| ev_clear_num | input | 7 | Event number to clear |
| bus_wr_en | input | 1 | Register write strobe |
| bus_addr | input | 4 | Register word address |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Registered read data |
| irq_out | output | 3 | Interrupt requests: [0] level 13, [1] level 11, [2] level 9 |

## Verification
The bench builds the block with its default parameters: 32-bit words, three interrupt levels and a 4-bit address. With these values the whole 7-bit event space can be driven. That includes the fourth, unmapped word select and the two reserved summary positions. The read mux also has four spare addresses above the mask bank, so the zero readback and ignored writes there can be exercised. The 32-bit width also places the summary bits at 30 and 31, where the write rules and drain logic of the table-driven sequence act on them.

// File: rtl/evc_pkg.sv
package evc_pkg;
  // Number of pending words; the cascade scheme is defined for three.
  localparam int NUM_WORDS = 3;
  // Word-select width inside an event number.
  localparam int WSEL_W = 2;

  typedef enum logic [1:0] {
    WK_SUMMARY  = 2'd0,  // word 0: write-one-to-clear, summary bits protected
    WK_READONLY = 2'd1,  // word 1: bus writes ignored
    WK_DRAINING = 2'd2   // word 2: write-one-to-clear, drains summary bit
  } word_kind_e;

  function automatic word_kind_e kind_of(input int w);
    case (w)
      0:       return WK_SUMMARY;
      1:       return WK_READONLY;
      default: return WK_DRAINING;
    endcase
  endfunction
endpackage

// File: rtl/evc_event_decode.sv
module evc_event_decode #(
  parameter int WORD_W = 32,
  localparam int BIT_W = $clog2(WORD_W),
  localparam int EVT_W = BIT_W + evc_pkg::WSEL_W
) (
  input  logic                                         valid,
  input  logic [EVT_W-1:0]                             num,
  output logic [evc_pkg::NUM_WORDS-1:0][WORD_W-1:0]    vec
);
  logic [evc_pkg::WSEL_W-1:0] wsel;
  logic [BIT_W-1:0]           bsel;
  logic                       reserved;

  assign wsel     = num[EVT_W-1 -: evc_pkg::WSEL_W];
  assign bsel     = num[BIT_W-1:0];
  // Summary positions in word 0 are owned by the cascade logic.
  assign reserved = (wsel == '0) && (bsel >= BIT_W'(WORD_W-2));

  always_comb begin
    vec = '0;
    if (valid && !reserved && (wsel < evc_pkg::WSEL_W'(evc_pkg::NUM_WORDS)))
      vec[wsel][bsel] = 1'b1;
  end
endmodule

// File: rtl/evc_pend_word.sv
module evc_pend_word #(
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [WORD_W-1:0] set_bits,
  input  logic [WORD_W-1:0] clr_bits,
  output logic [WORD_W-1:0] pend_q
);
  // Set is applied after clear so a coincident raise survives.
  always_ff @(posedge clk) begin
    if (rst) pend_q <= '0;
    else     pend_q <= (pend_q & ~clr_bits) | set_bits;
  end
endmodule

// File: rtl/evc_mask_bank.sv
module evc_mask_bank #(
  parameter int WORD_W     = 32,
  parameter int NUM_LEVELS = 3,
  parameter int ADDR_W     = 4
) (
  input  logic                                                        clk,
  input  logic                                                        rst,
  input  logic                                                        wr_en,
  input  logic [ADDR_W-1:0]                                           addr,
  input  logic [WORD_W-1:0]                                           wdata,
  output logic [NUM_LEVELS-1:0][evc_pkg::NUM_WORDS-1:0][WORD_W-1:0]   mask_q
);
  localparam int NW = evc_pkg::NUM_WORDS;

  for (genvar l = 0; l < NUM_LEVELS; l++) begin : g_lvl
    for (genvar w = 0; w < NW; w++) begin : g_word
      localparam int MADDR = NW + l*NW + w;
      always_ff @(posedge clk) begin
        if (rst)
          mask_q[l][w] <= '0;
        else if (wr_en && (addr == ADDR_W'(MADDR)))
          mask_q[l][w] <= wdata;
      end
    end
  end
endmodule

// File: rtl/evc_irq_gen.sv
module evc_irq_gen #(
  parameter int WORD_W     = 32,
  parameter int NUM_LEVELS = 3
) (
  input  logic                                                        clk,
  input  logic                                                        rst,
  input  logic [evc_pkg::NUM_WORDS-1:0][WORD_W-1:0]                   pend,
  input  logic [NUM_LEVELS-1:0][evc_pkg::NUM_WORDS-1:0][WORD_W-1:0]   mask,
  output logic [NUM_LEVELS-1:0]                                       irq_q
);
  for (genvar l = 0; l < NUM_LEVELS; l++) begin : g_lvl
    logic hit;
    always_comb begin
      hit = 1'b0;
      for (int w = 0; w < evc_pkg::NUM_WORDS; w++)
        hit = hit | (|(pend[w] & mask[l][w]));
    end
    always_ff @(posedge clk) begin
      if (rst) irq_q[l] <= 1'b0;
      else     irq_q[l] <= hit;
    end
  end
endmodule

// File: rtl/evt_cascade_irq.sv
module evt_cascade_irq #(
  parameter int WORD_W     = 32,
  parameter int NUM_LEVELS = 3,
  parameter int ADDR_W     = 4,
  localparam int BIT_W = $clog2(WORD_W),
  localparam int EVT_W = BIT_W + evc_pkg::WSEL_W
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  ev_raise_valid,
  input  logic [EVT_W-1:0]      ev_raise_num,
  input  logic                  ev_clear_valid,
  input  logic [EVT_W-1:0]      ev_clear_num,
  input  logic                  bus_wr_en,
  input  logic [ADDR_W-1:0]     bus_addr,
  input  logic [WORD_W-1:0]     bus_wdata,
  output logic [WORD_W-1:0]     bus_rdata,
  output logic [NUM_LEVELS-1:0] irq_out
);
  import evc_pkg::*;

  localparam int NW      = NUM_WORDS;
  localparam int SUM_LO  = WORD_W - 2;   // summary of word 1
  localparam int SUM_HI  = WORD_W - 1;   // summary of word 2
  localparam logic [WORD_W-1:0] SUM_MASK = {2'b11, {(WORD_W-2){1'b0}}};

  logic [NW-1:0][WORD_W-1:0] hw_set, hw_clr, sw_clr, set_v, clr_v, pend_q;
  logic [NW-1:0]             drained;
  logic [NUM_LEVELS-1:0][NW-1:0][WORD_W-1:0] mask_q;

  evc_event_decode #(.WORD_W(WORD_W)) u_dec_set (
    .valid(ev_raise_valid), .num(ev_raise_num), .vec(hw_set));
  evc_event_decode #(.WORD_W(WORD_W)) u_dec_clr (
    .valid(ev_clear_valid), .num(ev_clear_num), .vec(hw_clr));

  // Per-word bus clear rule and drain detection.
  for (genvar w = 0; w < NW; w++) begin : g_word
    localparam word_kind_e KIND = kind_of(w);
    logic wr_hit;
    assign wr_hit = bus_wr_en && (bus_addr == ADDR_W'(w));

    if (KIND == WK_SUMMARY) begin : g_sum
      assign sw_clr[w]  = wr_hit ? (bus_wdata & ~SUM_MASK) : '0;
      assign drained[w] = 1'b0;
    end else begin : g_sub
      if (KIND == WK_READONLY) begin : g_ro
        assign sw_clr[w] = '0;
      end else begin : g_w1c
        assign sw_clr[w] = wr_hit ? bus_wdata : '0;
      end
      // A clear this cycle that leaves the word empty.
      assign drained[w] = (|(hw_clr[w] | sw_clr[w])) &&
        (((pend_q[w] & ~(hw_clr[w] | sw_clr[w])) | hw_set[w]) == '0);
      assign set_v[w] = hw_set[w];
      assign clr_v[w] = hw_clr[w] | sw_clr[w];
    end

    evc_pend_word #(.WORD_W(WORD_W)) u_word (
      .clk(clk), .rst(rst),
      .set_bits(set_v[w]), .clr_bits(clr_v[w]), .pend_q(pend_q[w]));
  end

  // Word 0 folds in the summary maintenance for words 1 and 2.
  always_comb begin
    set_v[0] = hw_set[0];
    set_v[0][SUM_LO] = |hw_set[1];
    set_v[0][SUM_HI] = |hw_set[2];
    clr_v[0] = hw_clr[0] | sw_clr[0];
    clr_v[0][SUM_LO] = drained[1];
    clr_v[0][SUM_HI] = drained[2];
  end

  evc_mask_bank #(.WORD_W(WORD_W), .NUM_LEVELS(NUM_LEVELS), .ADDR_W(ADDR_W)) u_masks (
    .clk(clk), .rst(rst), .wr_en(bus_wr_en), .addr(bus_addr),
    .wdata(bus_wdata), .mask_q(mask_q));

  evc_irq_gen #(.WORD_W(WORD_W), .NUM_LEVELS(NUM_LEVELS)) u_irq (
    .clk(clk), .rst(rst), .pend(pend_q), .mask(mask_q), .irq_q(irq_out));

  // Registered read mux over pending words then mask bank.
  logic [WORD_W-1:0] rd_mux;
  always_comb begin
    rd_mux = '0;
    for (int w = 0; w < NW; w++)
      if (bus_addr == ADDR_W'(w)) rd_mux = pend_q[w];
    for (int l = 0; l < NUM_LEVELS; l++)
      for (int w = 0; w < NW; w++)
        if (bus_addr == ADDR_W'(NW + l*NW + w)) rd_mux = mask_q[l][w];
  end

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else     bus_rdata <= rd_mux;
  end
endmodule

// File: rtl/evc_checker.sv
module evc_checker #(
  parameter int WORD_W     = 32,
  parameter int NUM_LEVELS = 3,
  localparam int BIT_W = $clog2(WORD_W),
  localparam int EVT_W = BIT_W + 2
) (
  input logic                        clk,
  input logic                        rst,
  input logic                        ev_raise_valid,
  input logic [EVT_W-1:0]            ev_raise_num,
  input logic                        ev_clear_valid,
  input logic [EVT_W-1:0]            ev_clear_num,
  input logic [2:0][WORD_W-1:0]      pend,
  input logic [NUM_LEVELS-1:0]       irq_out
);
  logic [1:0]       rw;
  logic [BIT_W-1:0] rb;
  logic             raise_ok;
  assign rw = ev_raise_num[EVT_W-1 -: 2];
  assign rb = ev_raise_num[BIT_W-1:0];
  assign raise_ok = ev_raise_valid && (rw != 2'd3) &&
                    !((rw == 2'd0) && (rb >= BIT_W'(WORD_W-2)));

  AST_RAISE_LANDS: assert property (@(posedge clk) disable iff (rst)
    raise_ok |=> pend[$past(rw)][$past(rb)]); // R1

  AST_SUMMARY_HI_TRACKS: assert property (@(posedge clk) disable iff (rst)
    pend[0][WORD_W-1] == (|pend[2])); // R2

  AST_SUMMARY_LO_TRACKS: assert property (@(posedge clk) disable iff (rst)
    pend[0][WORD_W-2] == (|pend[1])); // R3

  AST_WORD1_BUS_PROOF: assert property (@(posedge clk) disable iff (rst)
    !(ev_clear_valid && (ev_clear_num[EVT_W-1 -: 2] == 2'd1))
      |=> ((pend[1] & $past(pend[1])) == $past(pend[1]))); // R5

  AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (rst)
    $past(pend == '0) |-> (irq_out == '0)); // R7

  AST_RESET_CLEARS: assert property (@(posedge clk)
    rst |=> ((pend == '0) && (irq_out == '0))); // R9
endmodule

bind evt_cascade_irq evc_checker #(.WORD_W(WORD_W), .NUM_LEVELS(NUM_LEVELS)) u_chk (
  .clk(clk), .rst(rst),
  .ev_raise_valid(ev_raise_valid), .ev_raise_num(ev_raise_num),
  .ev_clear_valid(ev_clear_valid), .ev_clear_num(ev_clear_num),
  .pend(pend_q), .irq_out(irq_out));

// File: tb/evt_cascade_irq_test.sv
module evt_cascade_irq_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ev_raise_valid = 1'b0;
  logic [6:0]  ev_raise_num = '0;
  logic        ev_clear_valid = 1'b0;
  logic [6:0]  ev_clear_num = '0;
  logic        bus_wr_en = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [2:0]  irq_out;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  evt_cascade_irq uut (
    .clk(clk), .rst(rst),
    .ev_raise_valid(ev_raise_valid), .ev_raise_num(ev_raise_num),
    .ev_clear_valid(ev_clear_valid), .ev_clear_num(ev_clear_num),
    .bus_wr_en(bus_wr_en), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq_out(irq_out));

  // op: 0 raise, 1 hardware clear, 2 bus write (num[3:0] = address)
  typedef struct packed {
    logic [1:0]  op;
    logic [6:0]  num;
    logic [31:0] data;
    logic [31:0] e0;
    logic [31:0] e1;
    logic [31:0] e2;
  } vec_t;

  localparam int NV = 15;
  localparam vec_t VEC [NV] = '{
    '{2'd0, 7'd5,   32'h0,        32'h0000_0020, 32'h0, 32'h0},
    '{2'd0, 7'd33,  32'h0,        32'h4000_0020, 32'h2, 32'h0},
    '{2'd0, 7'd70,  32'h0,        32'hC000_0020, 32'h2, 32'h40},
    '{2'd2, 7'd0,   32'hFFFF_FFFF,32'hC000_0000, 32'h2, 32'h40},
    '{2'd2, 7'd1,   32'hFFFF_FFFF,32'hC000_0000, 32'h2, 32'h40},
    '{2'd1, 7'd33,  32'h0,        32'h8000_0000, 32'h0, 32'h40},
    '{2'd0, 7'd95,  32'h0,        32'h8000_0000, 32'h0, 32'h8000_0040},
    '{2'd2, 7'd2,   32'h40,       32'h8000_0000, 32'h0, 32'h8000_0000},
    '{2'd2, 7'd2,   32'h8000_0000,32'h0,         32'h0, 32'h0},
    '{2'd0, 7'd31,  32'h0,        32'h0,         32'h0, 32'h0},
    '{2'd0, 7'd100, 32'h0,        32'h0,         32'h0, 32'h0},
    '{2'd0, 7'd64,  32'h0,        32'h8000_0000, 32'h0, 32'h1},
    '{2'd1, 7'd31,  32'h0,        32'h8000_0000, 32'h0, 32'h1},
    '{2'd1, 7'd65,  32'h0,        32'h8000_0000, 32'h0, 32'h1},
    '{2'd1, 7'd64,  32'h0,        32'h0,         32'h0, 32'h0}
  };

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, got, exp);
    end
  endtask

  task automatic apply(input logic [1:0] op, input logic [6:0] num, input logic [31:0] data);
    @(negedge clk);
    case (op)
      2'd0: begin ev_raise_valid = 1'b1; ev_raise_num = num; end
      2'd1: begin ev_clear_valid = 1'b1; ev_clear_num = num; end
      default: begin bus_wr_en = 1'b1; bus_addr = num[3:0]; bus_wdata = data; end
    endcase
    @(negedge clk);
    ev_raise_valid = 1'b0; ev_clear_valid = 1'b0; bus_wr_en = 1'b0;
  endtask

  task automatic read_reg(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    @(posedge clk);
    #1 d = bus_rdata;
  endtask

  task automatic check_irq(input string tag, input logic [2:0] exp);
    @(posedge clk);
    #1 check(tag, {29'd0, irq_out}, {29'd0, exp});
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL R12 watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;

    // R9: reset state of every register and the outputs
    check("R9 irq after reset", {29'd0, irq_out}, 32'h0);
    for (int a = 0; a < 12; a++) begin
      read_reg(4'(a), d);
      check($sformatf("R9 reg %0d after reset", a), d, 32'h0);
    end
    // R12: spare addresses read zero
    for (int a = 12; a < 16; a++) begin
      read_reg(4'(a), d);
      check($sformatf("R12 spare addr %0d", a), d, 32'h0);
    end

    // Table walk: R1 R2 R3 R4 R5 R6 R11
    for (int i = 0; i < NV; i++) begin
      apply(VEC[i].op, VEC[i].num, VEC[i].data);
      read_reg(4'd0, d); check($sformatf("R1 R2 R4 vec %0d word0", i), d, VEC[i].e0);
      read_reg(4'd1, d); check($sformatf("R3 R5 vec %0d word1", i), d, VEC[i].e1);
      read_reg(4'd2, d); check($sformatf("R6 R11 vec %0d word2", i), d, VEC[i].e2);
    end

    // R8: mask read/write at 3 + 3*L + w
    apply(2'd2, 7'd3,  32'h0000_0400);   // level 13, word 0
    apply(2'd2, 7'd8,  32'h0000_0001);   // level 11, word 2
    apply(2'd2, 7'd9,  32'h4000_0000);   // level 9, word 0 summary bit 30
    read_reg(4'd3, d);  check("R8 mask L13 w0", d, 32'h0000_0400);
    read_reg(4'd8, d);  check("R8 mask L11 w2", d, 32'h0000_0001);
    read_reg(4'd9, d);  check("R8 mask L9 w0", d, 32'h4000_0000);
    read_reg(4'd5, d);  check("R8 mask L13 w2 untouched", d, 32'h0);

    // R7: level outputs, one clock behind pending
    apply(2'd0, 7'd10, 32'h0);
    check_irq("R7 level13 from word0 bit10", 3'b001);
    apply(2'd0, 7'd64, 32'h0);
    check_irq("R7 level11 from word2 bit0", 3'b011);
    apply(2'd0, 7'd40, 32'h0);
    check_irq("R7 level9 via summary bit30", 3'b111);
    apply(2'd1, 7'd40, 32'h0);
    check_irq("R3 R7 summary drop removes level9", 3'b011);
    apply(2'd2, 7'd0, 32'h0000_0400);
    check_irq("R4 R7 bus clear removes level13", 3'b010);
    apply(2'd1, 7'd64, 32'h0);
    check_irq("R7 all quiet", 3'b000);

    // R10: raise beats hardware clear on the same bit
    @(negedge clk);
    ev_raise_valid = 1'b1; ev_raise_num = 7'd12;
    ev_clear_valid = 1'b1; ev_clear_num = 7'd12;
    @(negedge clk);
    ev_raise_valid = 1'b0; ev_clear_valid = 1'b0;
    read_reg(4'd0, d); check("R10 raise vs hw clear", d, 32'h0000_1000);
    // R10: raise beats bus write-one-to-clear on the same bit
    @(negedge clk);
    ev_raise_valid = 1'b1; ev_raise_num = 7'd13;
    bus_wr_en = 1'b1; bus_addr = 4'd0; bus_wdata = 32'h0000_2000;
    @(negedge clk);
    ev_raise_valid = 1'b0; bus_wr_en = 1'b0;
    read_reg(4'd0, d); check("R10 raise vs bus clear", d, 32'h0000_3000);
    apply(2'd2, 7'd0, 32'h0000_3000);
    read_reg(4'd0, d); check("R4 bus clear both", d, 32'h0);

    // R12: write to spare address ignored
    apply(2'd2, 7'd13, 32'hFFFF_FFFF);
    read_reg(4'd13, d); check("R12 spare write reads zero", d, 32'h0);
    read_reg(4'd3, d);  check("R12 spare write leaves mask", d, 32'h0000_0400);
    read_reg(4'd0, d);  check("R12 spare write leaves word0", d, 32'h0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule